// File: doc/BRIEF.md
# Deep-Sleep Pin Wakeup Edge Detector

This block watches a group of general-purpose pins while the rest of the chip sleeps. It runs on a slow clock that stays on during sleep. Each pin is asynchronous to that clock, so it first passes through a two-stage synchronizer. A digital filter then accepts a new pin level only after the level has been sampled unchanged on a set number of consecutive clock edges. When an enabled pin settles at a new level, whether it rose or fell, the block sets a sticky status bit for that pin.

A registered wakeup output stays high while any status bit whose pin is enabled is set. The power sequencer uses this output to start the wake sequence. Once the system is awake, software reads the status vector to find which pins caused the wakeup. It clears bits by writing ones to them. Bits written with zero keep their value.

For each pin, the filter keeps tracking the pin level even while the pin is disabled. A change that happened while the pin was disabled is therefore never reported later. After reset, the filter takes the first settled level of each pin as its starting point, so a pin that is already high when reset is released does not cause a wakeup.

Top module: `wake_edge_detector`

## Requirements
- R1: A low-to-high change on an enabled pin sets that pin's bit in `status_o`. Counting the clock edge that first samples the new level as edge 1, the bit is visible after edge 4 when `STABLE_CYCLES` is 2.
- R2: A high-to-low change on an enabled pin sets that pin's status bit with the same latency as R1.
- R3: A new level is accepted only if the synchronized value stays the same for `STABLE_CYCLES` consecutive samples. With the default of 2, a pulse that is sampled on one clock edge only sets nothing. A pulse that is sampled on two edges sets the bit.
- R4: A cycle with `clr_we_i` high clears every status bit whose bit in `clr_data_i` is 1. Bits written with 0 keep their value. Status bits stay set until they are cleared in this way.
- R5: If a filtered change and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A pin whose bit in `en_i` is 0 never sets its status bit. A change that settles while the pin is disabled is not reported after the pin is enabled again.
- R7: `wake_o` is a register equal to the OR of (status AND `en_i`). It reflects the same cycle's status update, and it drops one cycle after `en_i` masks the last set bit.
- R8: While `rst` is high, `status_o` and `wake_o` are 0. A pin level that is already present when reset is released does not set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on functional clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | PINS | Asynchronous pin levels |
| en_i | input | PINS | Per-pin wakeup enable |
| clr_we_i | input | 1 | Write strobe for clearing status |
| clr_data_i | input | PINS | Write data; a 1 clears the matching status bit |
| status_o | output | PINS | Sticky per-pin event status, read by software |
| wake_o | output | 1 | Level wakeup request to the power sequencer |

## Verification
The bench builds the block with `PINS` = 16 and `STABLE_CYCLES` = 2.

The 16-pin width makes it possible to move pins at both ends and in the middle of the group in one vector, so several pins can set and clear in the same cycle. The filter length of two makes the shortest rejected pulse (one sample) and the shortest accepted pulse (two samples) only one cycle apart.

With the latency fixed at four edges, the bench can time a clear write to land on the exact cycle in which an event is captured. This covers the collision case in R5.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int DEF_PINS   = 16;
  localparam int DEF_STABLE = 2;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wk_filter.sv
module wk_filter #(
  parameter int W      = 16,
  parameter int STABLE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] evt_o
);
  import wk_pkg::*;
  localparam int HDEPTH = (STABLE > 1) ? STABLE - 1 : 1;
  localparam int WARM   = STABLE + SYNC_STAGES;
  localparam int CW     = $clog2(WARM + 1);

  logic [W-1:0] hist_q [HDEPTH];
  logic [W-1:0] flt_q;
  logic [W-1:0] armed_q;
  logic [W-1:0] agree;
  logic [CW-1:0] warm_q;
  logic          ready;

  assign ready = (warm_q == CW'(WARM));

  always_comb begin
    agree = '1;
    if (STABLE > 1) begin
      for (int i = 0; i < HDEPTH; i++) agree &= ~(hist_q[i] ^ smp_i);
    end
  end

  assign evt_o = agree & armed_q & (smp_i ^ flt_q);

  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (!ready) warm_q <= warm_q + 1'b1;
  end

  generate
    for (genvar g = 0; g < HDEPTH; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (rst) hist_q[g] <= '0;
        else if (g == 0) hist_q[g] <= smp_i;
        else hist_q[g] <= hist_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q   <= '0;
      armed_q <= '0;
    end else if (ready) begin
      for (int b = 0; b < W; b++) begin
        if (agree[b]) begin
          flt_q[b]   <= smp_i[b];
          armed_q[b] <= 1'b1;
        end
      end
    end
  end

  AST_FLT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (flt_q != $past(flt_q)) |-> ($past(smp_i) == $past(hist_q[HDEPTH-1]))) // R3
    else $error("filtered level moved without a settled window");
endmodule

// File: rtl/wk_status.sv
module wk_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] status_o,
  output logic         wake_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;
  logic [W-1:0] clr_mask;
  logic         wake_q;

  assign clr_mask = clr_we_i ? clr_data_i : '0;
  assign status_d = (status_q & ~clr_mask) | (evt_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      wake_q   <= |(status_d & en_i);
    end
  end

  assign status_o = status_q;
  assign wake_o   = wake_q;

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (($past(status_q) & ~status_q & ~($past(clr_we_i) ? $past(clr_data_i) : '0)) == '0)) // R4
    else $error("status bit dropped without a clear write");

  AST_NO_DISABLED_SET: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(en_i)) == '0)) // R6
    else $error("disabled pin set its status");

  AST_WAKE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    wake_q == (|(status_q & $past(en_i)))) // R7
    else $error("wake level does not match masked status");
endmodule

// File: rtl/wake_edge_detector.sv
module wake_edge_detector #(
  parameter int PINS          = wk_pkg::DEF_PINS,
  parameter int STABLE_CYCLES = wk_pkg::DEF_STABLE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] en_i,
  input  logic            clr_we_i,
  input  logic [PINS-1:0] clr_data_i,
  output logic [PINS-1:0] status_o,
  output logic            wake_o
);
  logic [PINS-1:0] smp;
  logic [PINS-1:0] evt;

  wk_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(smp)
  );

  wk_filter #(.W(PINS), .STABLE(STABLE_CYCLES)) u_filter (
    .clk(clk), .rst(rst), .smp_i(smp), .evt_o(evt)
  );

  wk_status #(.W(PINS)) u_status (
    .clk(clk), .rst(rst), .evt_i(evt), .en_i(en_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .status_o(status_o), .wake_o(wake_o)
  );
endmodule

// File: tb/wake_edge_detector_bench.sv
module wake_edge_detector_bench;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pin = '0, en = '1, clr = '0;
  logic clr_we = 1'b0;
  logic [W-1:0] status;
  logic wake;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  wake_edge_detector #(.PINS(W), .STABLE_CYCLES(2)) u_wake_edge_detector (
    .clk(clk), .rst(rst), .pin_i(pin), .en_i(en), .clr_we_i(clr_we),
    .clr_data_i(clr), .status_o(status), .wake_o(wake)
  );

  // {pins, enable, clear strobe, clear data, expected status, expected wake}
  localparam logic [65:0] VEC [0:9] = '{
    {16'h0001, 16'hFFFF, 1'b0, 16'h0000, 16'h0001, 1'b1}, // R1 rise
    {16'h0000, 16'hFFFF, 1'b1, 16'h0001, 16'h0001, 1'b1}, // R2 fall after clear
    {16'h0000, 16'hFFFF, 1'b1, 16'h0001, 16'h0000, 1'b0}, // R4 clear
    {16'h8000, 16'hFFFF, 1'b1, 16'h0000, 16'h8000, 1'b1}, // R1 zero write
    {16'h8000, 16'hFFFF, 1'b1, 16'h0000, 16'h8000, 1'b1}, // R4 zeros keep
    {16'h8100, 16'h00FF, 1'b0, 16'h0000, 16'h8000, 1'b0}, // R6 R7 masked
    {16'h8100, 16'h00FF, 1'b1, 16'hFFFF, 16'h0000, 1'b0}, // R4 clear all
    {16'h8100, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 1'b0}, // R6 no late event
    {16'h00F0, 16'hFFFF, 1'b0, 16'h0000, 16'h81F0, 1'b1}, // R1 R2 mixed
    {16'h00F0, 16'hFFFF, 1'b1, 16'h81F0, 16'h0000, 1'b0}  // R4 multi clear
  };

  task automatic check(input string req, input logic [W-1:0] gs, input logic [W-1:0] es,
                       input logic gw, input logic ew);
    checks++;
    if (gs !== es || gw !== ew) begin
      errors++;
      $display("FAIL %s: status=%h wake=%b expected status=%h wake=%b", req, gs, gw, es, ew);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R1: cycles=%0d expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", status, '0, wake, 1'b0);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      {pin, en, clr_we, clr} = VEC[i][65:17];
      @(negedge clk);
      clr_we = 1'b0;
      repeat (6) @(negedge clk);
      check($sformatf("R1/R2/R4/R6/R7 vector %0d", i), status, VEC[i][16:1], wake, VEC[i][0]);
    end

    // R3: pulse sampled on one edge is rejected
    pin = 16'h00F8;
    @(negedge clk);
    pin = 16'h00F0;
    repeat (8) @(negedge clk);
    check("R3 one-sample glitch", status, '0, wake, 1'b0);

    // R3: pulse sampled on two edges is accepted
    pin = 16'h00F8;
    repeat (2) @(negedge clk);
    pin = 16'h00F0;
    repeat (8) @(negedge clk);
    check("R3 two-sample pulse", status, 16'h0008, wake, 1'b1);

    // R5: clear lands in the capture cycle of a new bit2 event
    pin = 16'h00F4;
    repeat (3) @(negedge clk);
    clr_we = 1'b1; clr = 16'h000C;
    @(negedge clk);
    clr_we = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 event beats clear", status, 16'h0004, wake, 1'b1);

    clr_we = 1'b1; clr = 16'hFFFF;
    @(negedge clk);
    clr_we = 1'b0;
    @(negedge clk);
    check("R4 R7 full clear", status, '0, wake, 1'b0);

    // R8: level held through reset release is not an event
    pin = 16'h0003;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset again", status, '0, wake, 1'b0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 level at release", status, '0, wake, 1'b0);

    pin = 16'h0001;
    repeat (6) @(negedge clk);
    check("R2 fall after rearm", status, 16'h0002, wake, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule